// File: doc/BRIEF.md
# I/O Wake-Up Daisy Chain Controller

This block sits between a power controller's register interface and a row of per-pad wake-up detectors. Software turns pad wake-up detection on or off by writing a chain direction bit. The controller then passes a single token down the pads. The token moves one pad for each pulse of a slow wake-up clock enable, not on every bus clock. When the token leaves the last pad, a sticky completion flag is set. Software polls this flag and clears it by writing 1 before it lets the domain power down.

Once an arming pass has finished, an event on a pad whose own enable is set is latched in that pad. A global I/O wake enable gates whether any latched pad event drives the wake-up request. While the request is high, a sticky wake-source flag records that an I/O pad caused the wake-up. A later disarming pass stops latching as soon as it starts, and it wipes every latched event when it completes.

Top module: `iowk_chain_ctrl`

## Requirements
- R1: After reset, the control word (address 0) and the status word (address 1) both read 0, and `wake_req` is 0.
- R2: A write to address 0 whose bit 16 differs from the bit 16 read back starts a pass, with direction equal to that bit (1 arms, 0 disarms). Bit 16 reads back the new value from the next cycle.
- R3: A pass moves one pad per cycle in which `step_en` is high. Status bit 16 reads 1 from the cycle after the NPADS-th such pulse and not before. `step_en` has no effect when no pass is running.
- R4: Status bit 16 stays set until a write to address 1 with bit 16 set clears it. A write with bit 16 clear leaves it unchanged. If a pass ends in the same cycle, the set wins.
- R5: Control bit 8 is the global I/O wake enable. While it is 0, `wake_req` is 0 whatever the pads hold. A write to address 0 updates it even while a pass is running.
- R6: A pad whose `pad_en` bit is 0 neither latches its event nor contributes to `wake_req`.
- R7: A write to address 0 while a pass is running leaves bit 16 and the running pass unchanged. Completion still follows the original NPADS pulses.
- R8: A pad event is latched only after an arming pass has completed. An event latched in cycle t makes `wake_req` high from cycle t+1. Events before completion leave `wake_req` at 0.
- R9: A disarming pass stops new latching from the cycle after its start. When it completes, all latched events are cleared, so `wake_req` falls in the following cycle.
- R10: Status bit 8 sets in the cycle after `wake_req` is high, and stays set until a write to address 1 with bit 8 set clears it. A wake-up request that is still present in that cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| step_en | input | 1 | Wake-up clock enable; one chain step per high cycle |
| pad_evt | input | NPADS | Per-pad wake events |
| pad_en | input | NPADS | Per-pad wake enables |
| wake_req | output | 1 | Wake-up request |

## Verification
Register writes take effect at the next clock edge. Read data follows `reg_addr` with no delay, so control and status values are due one cycle after the write or the step pulse that changes them. A pad event appears on `wake_req` one cycle after it is presented, and the wake-source flag one cycle later still. The bench drives inputs at the falling edge and advances a reference model by one edge for each cycle. It compares `wake_req` and both register words at the next falling edge, which matches those one-edge latencies. Completion is checked at every pulse, so a flag raised one pulse early or late is caught.

// File: rtl/iowk_pkg.sv
package iowk_pkg;
  localparam int DATA_W    = 32;
  localparam bit ADDR_CTRL = 1'b0;
  localparam bit ADDR_STAT = 1'b1;
  localparam int POS_CHAIN = 16;
  localparam int POS_IO    = 8;

  function automatic logic [DATA_W-1:0] pack_pair(input logic hi, input logic lo);
    logic [DATA_W-1:0] w;
    w = '0;
    w[POS_CHAIN] = hi;
    w[POS_IO]    = lo;
    return w;
  endfunction

  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/iowk_regs.sv
module iowk_regs
  import iowk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic              pass_end,
  input  logic              wake_req,
  output logic              start,
  output logic              chain_dir,
  output logic              io_en,
  output logic [DATA_W-1:0] rdata
);
  logic stat_done, stat_src;
  logic ctrl_wr, stat_wr;
  logic unused_bits;

  assign ctrl_wr = wr && (addr == ADDR_CTRL);
  assign stat_wr = wr && (addr == ADDR_STAT);
  assign start   = ctrl_wr && (wdata[POS_CHAIN] != chain_dir) && !busy;
  assign unused_bits = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_dir <= 1'b0;
      io_en     <= 1'b0;
      stat_done <= 1'b0;
      stat_src  <= 1'b0;
    end else begin
      if (start)   chain_dir <= wdata[POS_CHAIN];
      if (ctrl_wr) io_en     <= wdata[POS_IO];
      stat_done <= sticky_next(stat_done, pass_end, stat_wr && wdata[POS_CHAIN]);
      stat_src  <= sticky_next(stat_src,  wake_req, stat_wr && wdata[POS_IO]);
    end
  end

  assign rdata = (addr == ADDR_CTRL) ? pack_pair(chain_dir, io_en)
                                     : pack_pair(stat_done, stat_src);

  p_done_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pass_end |=> stat_done);
  p_done_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && wdata[POS_CHAIN] && !pass_end) |=> !stat_done);
  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctrl_wr) |=> $stable(chain_dir));
  p_src_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> stat_src);
endmodule

// File: rtl/iowk_chain.sv
module iowk_chain #(
  parameter int NPADS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dir,
  input  logic             step_en,
  output logic             busy,
  output logic             pass_end,
  output logic             live,
  output logic             clr_all,
  output logic [NPADS-1:0] armed
);
  logic [NPADS-1:0] token;
  logic             pass_dir;

  assign busy     = |token;
  assign pass_end = step_en && token[NPADS-1];
  assign clr_all  = pass_end && !pass_dir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_dir <= 1'b0;
      live     <= 1'b0;
    end else begin
      if (start) begin
        pass_dir <= dir;
        if (!dir) live <= 1'b0;
      end else if (pass_end && pass_dir) begin
        live <= 1'b1;
      end
    end
  end

  genvar i;
  generate
    for (i = 0; i < NPADS; i++) begin : g_stage
      logic tok_in;
      if (i == 0) begin : g_head
        assign tok_in = 1'b0;
      end else begin : g_link
        assign tok_in = token[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          token[i] <= 1'b0;
          armed[i] <= 1'b0;
        end else if (start) begin
          token[i] <= (i == 0);
        end else if (step_en) begin
          token[i] <= tok_in;
          if (token[i]) armed[i] <= pass_dir;
        end
      end
    end
  endgenerate

  p_token_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(token));
  p_start_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/iowk_pad.sv
module iowk_pad (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic en,
  input  logic armed,
  input  logic live,
  input  logic clr,
  output logic lat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          lat <= 1'b0;
    else if (clr)                        lat <= 1'b0;
    else if (evt && en && armed && live) lat <= 1'b1;
  end

  p_no_latch_unarmed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!lat && !(armed && live)) |=> !lat);
  p_no_latch_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!lat && !en) |=> !lat);
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !lat);
endmodule

// File: rtl/iowk_chain_ctrl.sv
module iowk_chain_ctrl
  import iowk_pkg::*;
#(
  parameter int NPADS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              step_en,
  input  logic [NPADS-1:0]  pad_evt,
  input  logic [NPADS-1:0]  pad_en,
  output logic              wake_req
);
  logic             start, chain_dir, io_en;
  logic             busy, pass_end, live, clr_all;
  logic [NPADS-1:0] armed, lat;

  iowk_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .busy(busy), .pass_end(pass_end), .wake_req(wake_req),
    .start(start), .chain_dir(chain_dir), .io_en(io_en), .rdata(reg_rdata)
  );

  iowk_chain #(.NPADS(NPADS)) u_chain (
    .clk(clk), .rst_n(rst_n), .start(start), .dir(reg_wdata[POS_CHAIN]),
    .step_en(step_en), .busy(busy), .pass_end(pass_end), .live(live),
    .clr_all(clr_all), .armed(armed)
  );

  genvar i;
  generate
    for (i = 0; i < NPADS; i++) begin : g_pad
      iowk_pad u_pad (
        .clk(clk), .rst_n(rst_n), .evt(pad_evt[i]), .en(pad_en[i]),
        .armed(armed[i]), .live(live), .clr(clr_all), .lat(lat[i])
      );
    end
  endgenerate

  assign wake_req = io_en && |(lat & pad_en);

  p_disarm_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> !wake_req);
endmodule

// File: tb/iowk_chain_ctrl_bench.sv
`timescale 1ns/1ps
module iowk_chain_ctrl_bench;
  localparam int N = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic          reg_addr = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          step_en = 1'b0;
  logic [N-1:0]  pad_evt = '0;
  logic [N-1:0]  pad_en = '0;
  logic          wake_req;

  int n_chk = 0, n_fail = 0;

  bit arm_m, glob_m, done_m, src_m, live_m;
  logic [N-1:0] lat_m;
  int left_m;

  always #2.5 clk = ~clk;

  iowk_chain_ctrl #(.NPADS(N)) u_iowk_chain_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .step_en(step_en),
    .pad_evt(pad_evt), .pad_en(pad_en), .wake_req(wake_req)
  );

  function automatic logic [31:0] word_of(input bit b16, input bit b8);
    return (32'(b16) << 16) | (32'(b8) << 8);
  endfunction

  function automatic bit req_of(input bit g, input logic [N-1:0] l, input logic [N-1:0] e);
    return g && ((l & e) != '0);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    reg_addr = 1'b0; #0.2;
    check({tag, " ctrl R2 R5"}, reg_rdata, word_of(arm_m, glob_m));
    reg_addr = 1'b1; #0.2;
    check({tag, " stat R3 R4 R10"}, reg_rdata, word_of(done_m, src_m));
    check({tag, " wake_req R5 R6 R8"}, 32'(wake_req), 32'(req_of(glob_m, lat_m, pad_en)));
  endtask

  // One bus clock: drive at the falling edge, step the model over the rising edge, compare.
  task automatic cyc(input bit wr, input bit addr, input logic [31:0] wd,
                     input bit st, input logic [N-1:0] ev, input string tag);
    bit start, endp, req_old;
    req_old = req_of(glob_m, lat_m, pad_en);
    reg_wr = wr; reg_addr = addr; reg_wdata = wd; step_en = st; pad_evt = ev;
    start = wr && !addr && (wd[16] != arm_m) && (left_m == 0);
    endp = 0;
    if (live_m) lat_m = lat_m | (ev & pad_en);
    if (start) begin
      arm_m = wd[16]; left_m = N;
      if (!wd[16]) live_m = 0;
    end else if (st && left_m > 0) begin
      left_m--;
      if (left_m == 0) begin
        endp = 1;
        if (arm_m) live_m = 1; else lat_m = '0;
      end
    end
    if (wr && addr && wd[16]) done_m = 0;
    if (endp) done_m = 1;
    if (wr && addr && wd[8]) src_m = 0;
    if (req_old) src_m = 1;
    if (wr && !addr) glob_m = wd[8];
    @(negedge clk);
    reg_wr = 0; step_en = 0; pad_evt = '0;
    check_all(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, '0, tag);
  endtask

  task automatic run_pass(input bit dir, input bit glob, input string tag);
    cyc(1, 0, word_of(dir, glob), 0, '0, tag);
    for (int k = 0; k < N; k++) begin
      cyc(0, 0, 0, 1, '0, tag);
      idle(k % 3, tag);
    end
  endtask

  initial begin
    #(200000 * 5.0);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d0c_a11));
    arm_m = 0; glob_m = 0; done_m = 0; src_m = 0; live_m = 0; lat_m = '0; left_m = 0;
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after release");

    pad_en = 8'b1010_0101;
    cyc(1, 0, word_of(0, 1), 0, '0, "R5 global on");
    for (int k = 0; k < 4; k++) cyc(0, 0, 0, k[0], 8'hFF, "R3 R8 events before arming");

    // Arming pass with a rejected request in the middle.
    cyc(1, 0, word_of(1, 1), 0, '0, "R2 start arm");
    for (int k = 0; k < N; k++) begin
      cyc(0, 0, 0, 1, 8'hFF, "R3 R8 step");
      if (k == 3) cyc(1, 0, word_of(0, 1), 0, '0, "R7 write while busy");
    end
    cyc(1, 1, word_of(0, 0), 0, '0, "R4 write zero keeps done");

    cyc(0, 0, 0, 0, 8'b0000_0010, "R6 masked pad");
    cyc(0, 0, 0, 0, 8'b0000_0100, "R8 enabled pad");
    idle(2, "R10 source set");
    cyc(1, 1, word_of(1, 1), 0, '0, "R4 R10 clear both, request still high");
    cyc(1, 0, word_of(1, 0), 0, '0, "R5 global off");
    cyc(1, 0, word_of(1, 1), 0, '0, "R5 global on again");

    // Disarming pass, then clears.
    run_pass(0, 1, "R9 disarm");
    cyc(0, 0, 0, 0, 8'hFF, "R9 no latching after disarm");
    cyc(1, 1, word_of(1, 1), 0, '0, "R4 R10 clear");
    idle(2, "R10 stays clear");

    // Random phase.
    for (int k = 0; k < 4000; k++) begin
      bit wr, addr, st;
      logic [31:0] wd;
      if ($urandom_range(0, 49) == 0) pad_en = N'($urandom);
      wr   = ($urandom_range(0, 9) == 0);
      addr = $urandom_range(0, 1) != 0;
      wd   = word_of($urandom_range(0, 1) != 0, $urandom_range(0, 3) != 0);
      st   = ($urandom_range(0, 2) == 0);
      cyc(wr, addr, wd, st, ($urandom_range(0, 3) == 0) ? N'($urandom) : '0,
          "random R2 R3 R4 R6 R7 R8 R9 R10");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule